// File: doc/BRIEF.md
# Converter Input Source Selector with Result Validity Tracking

This block sits between the command decoder of a power-supply control module and its integrating analog-to-digital converter. It holds the 2-bit input-source setting for the converter, drives the analog routing switches that follow from it, and decides whether the last conversion result may be trusted. Software changes the source through a mode write, reads it back through a mode read, and fetches the most recent conversion word through a result read. Every request gets a one-cycle-late response carrying a Q bit that accepts or refuses the request.

Two protections are built in. Moving into or out of the self-test source is refused unless the set point and the DAC register are both zero and no ramp is running. Also, an integrating converter needs a settling time after its input moves. So any event that disturbs the converter input clears the valid flag and restarts a hold-off timer of roughly 0.92 s. Such events are a source change, a DAC update while the DAC feeds the converter, and ramp activity in monitor mode. The flag is set again only by a conversion that completes after the hold-off has run out. The converter itself and the DAC ramp generator lie outside this block; they supply the conversion-done strobe, the result word, the ramp indicator and the DAC-update strobe.

Top module: `adc_source_guard`

## Requirements
- R1: While `rst_n` is low and right after it rises, `mode_out` is 00, `data_valid` is 0, the three routing outputs are 0 and `rsp_valid` is 0. Reset does not clear the stored conversion word.
- R2: Source encoding on `mode_out` and in mode writes: 00 = second analog input, 01 = first analog input, 10 = DAC monitor, 11 = self-test. A mode write (`req_op` = 00) to a new value where neither the old nor the new value is 11 is always accepted, and `mode_out` shows the new value one cycle later.
- R3: A mode write that would enter or leave self-test (11) is accepted only when `setpoint_zero` = 1, `dac_zero` = 1 and `ramp_active` = 0. Otherwise the response has Q = 0 and `mode_out` keeps its value.
- R4: In self-test, `aout_hold_zero`, `ext_in_isolate` and `dac_to_adc` are all 1. In DAC monitor only `dac_to_adc` is 1. In both analog-input modes all three are 0.
- R5: Let HOLD = CLK_HZ/1000 × HOLD_MS cycles, and let an invalidating event be sampled at edge t. A `conv_done` sampled at edges t+1 through t+HOLD leaves `data_valid` at 0. A `conv_done` sampled at edge t+HOLD+1 or later, with no new event, sets `data_valid` at that edge.
- R6: Invalidating events clear `data_valid` at the next edge and restart the hold-off. They are: an accepted mode write that changes the source; `dac_update` while the source is 10 or 11; and `ramp_active` while the source is 10. `dac_update` in sources 00 and 01 has no effect, and neither has `ramp_active` outside source 10.
- R7: Every request sampled at an edge produces `rsp_valid` = 1 after that edge. A mode read (`req_op` = 01) returns Q = 1 with the source in `rsp_data[1:0]` and zeros above. A result read (`req_op` = 10) returns the last stored conversion word with Q equal to `data_valid` as it stood at the request. The reserved code 11 returns Q = 0 and zero data.
- R8: The conversion word is stored on every `conv_done`, valid or not, and survives a reset. After reset a result read returns it with Q = 0.
- R9: A mode write of the value already held returns Q = 1. It is never refused by the self-test guard and does not clear `data_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (crate reset and power-on) |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 00 mode write, 01 mode read, 10 result read, 11 reserved |
| req_wdata | input | 2 | Source code for a mode write |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_q | output | 1 | Accept / data-valid indication |
| rsp_data | output | RES_W | Read data |
| conv_done | input | 1 | Converter finished a conversion |
| conv_data | input | RES_W | Result word of that conversion |
| setpoint_zero | input | 1 | Set point register is zero |
| dac_zero | input | 1 | DAC register is zero |
| ramp_active | input | 1 | DAC ramp in progress |
| dac_update | input | 1 | DAC register changed this cycle |
| mode_out | output | 2 | Current input source |
| aout_hold_zero | output | 1 | Force analog output to 0 V |
| ext_in_isolate | output | 1 | Disconnect external analog input |
| dac_to_adc | output | 1 | Route DAC to converter input |
| data_valid | output | 1 | Last stored result may be trusted |

## Verification
The source-selection and validity logic is driven in two ways. Directed sequences place a conversion strobe exactly one cycle before and one cycle after the end of the hold-off, which separates an off-by-one timer from a correct one. The guard is also tried with each of its three conditions failing in turn, on both entry to and exit from self-test. Seeded random traffic then mixes requests of every code, including rewrites of the held value, with sparse DAC updates and ramp pulses in every source. This shows whether an invalidating event is recognised only in the sources where it matters, and whether result-read Q follows the flag state at the time of the request rather than after it.

// File: rtl/adc_guard_pkg.sv
package adc_guard_pkg;

    typedef enum logic [1:0] {
        SRC_AN2    = 2'b00,
        SRC_AN1    = 2'b01,
        SRC_DACMON = 2'b10,
        SRC_SELF   = 2'b11
    } src_mode_e;

    typedef enum logic [1:0] {
        OP_MODE_WR = 2'b00,
        OP_MODE_RD = 2'b01,
        OP_RES_RD  = 2'b10,
        OP_RSVD    = 2'b11
    } req_op_e;

    typedef struct packed {
        logic aout_zero;
        logic ext_off;
        logic loopback;
    } route_t;

endpackage

// File: rtl/adc_mode_ctrl.sv
module adc_mode_ctrl
    import adc_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_mode,
    input  logic       guard_ok,
    output logic [1:0] mode,
    output logic       wr_ok,
    output logic       changed
);

    typedef struct packed {
        src_mode_e mode;
    } mode_state_t;

    mode_state_t st_d, st_q;
    src_mode_e   want;
    logic        touches_self;

    always_comb begin
        st_d         = st_q;
        want         = src_mode_e'(wr_mode);
        touches_self = (want != st_q.mode) &&
                       ((want == SRC_SELF) || (st_q.mode == SRC_SELF));
        wr_ok        = !touches_self || guard_ok;
        changed      = wr_en && wr_ok && (want != st_q.mode);
        if (changed) begin
            st_d.mode = want;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: SRC_AN2};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;

    // R3: any transition touching self-test was guarded in the cycle it was taken
    assert_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode != $past(st_q.mode)) &&
         ((st_q.mode == SRC_SELF) || ($past(st_q.mode) == SRC_SELF)))
        |-> $past(guard_ok));

    // R2: without a write the source does not move
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(st_q.mode));

endmodule

// File: rtl/adc_holdoff_timer.sv
module adc_holdoff_timer #(
    parameter int unsigned HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);

    localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: LOAD};
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = (st_q.cnt == '0);

    // R5: every invalidating event reloads the full window
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> (st_q.cnt == LOAD));

    // R5: without a restart the window shrinks by exactly one per cycle
    assert_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && (st_q.cnt != '0)) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

endmodule

// File: rtl/adc_valid_tracker.sv
module adc_valid_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic invalidate,
    input  logic conv_done,
    input  logic expired,
    output logic valid
);

    typedef struct packed {
        logic valid;
    } vld_state_t;

    vld_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (invalidate) begin
            st_d.valid = 1'b0;
        end else if (conv_done && expired) begin
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;

    // R5: the flag only rises on a conversion finishing after the hold-off
    assert_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.valid) |-> $past(conv_done && expired && !invalidate));

    // R6: an invalidating event always drops the flag
    assert_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |=> !st_q.valid);

endmodule

// File: rtl/adc_source_guard.sv
module adc_source_guard
    import adc_guard_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned HOLD_MS = 920,
    parameter int unsigned RES_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [1:0]       req_wdata,
    output logic             rsp_valid,
    output logic             rsp_q,
    output logic [RES_W-1:0] rsp_data,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic             setpoint_zero,
    input  logic             dac_zero,
    input  logic             ramp_active,
    input  logic             dac_update,
    output logic [1:0]       mode_out,
    output logic             aout_hold_zero,
    output logic             ext_in_isolate,
    output logic             dac_to_adc,
    output logic             data_valid
);

    localparam int unsigned HOLD_CYC = (CLK_HZ / 1000) * HOLD_MS;

    typedef struct packed {
        logic             valid;
        logic             q;
        logic [RES_W-1:0] data;
    } rsp_t;

    req_op_e          op;
    logic             guard_ok;
    logic             mode_wr;
    logic             wr_ok;
    logic             changed;
    logic [1:0]       mode;
    logic             invalidate;
    logic             expired;
    logic             valid;
    logic [RES_W-1:0] res_q;
    rsp_t             rsp_d, rsp_q_r;
    route_t           route;

    assign op       = req_op_e'(req_op);
    assign guard_ok = setpoint_zero && dac_zero && !ramp_active;
    assign mode_wr  = req_valid && (op == OP_MODE_WR);

    adc_mode_ctrl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mode_wr),
        .wr_mode  (req_wdata),
        .guard_ok (guard_ok),
        .mode     (mode),
        .wr_ok    (wr_ok),
        .changed  (changed)
    );

    // Events that disturb what the converter sees
    always_comb begin
        invalidate = changed;
        if (dac_update && mode[1]) begin
            invalidate = 1'b1;
        end
        if (ramp_active && (src_mode_e'(mode) == SRC_DACMON)) begin
            invalidate = 1'b1;
        end
    end

    adc_holdoff_timer #(
        .HOLD_CYC (HOLD_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (invalidate),
        .expired (expired)
    );

    adc_valid_tracker u_valid (
        .clk        (clk),
        .rst_n      (rst_n),
        .invalidate (invalidate),
        .conv_done  (conv_done),
        .expired    (expired),
        .valid      (valid)
    );

    // Conversion word: deliberately outside reset
    always_ff @(posedge clk) begin
        if (conv_done) begin
            res_q <= conv_data;
        end
    end

    // Response path
    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            unique case (op)
                OP_MODE_WR: rsp_d.q = wr_ok;
                OP_MODE_RD: begin
                    rsp_d.q    = 1'b1;
                    rsp_d.data = RES_W'(mode);
                end
                OP_RES_RD: begin
                    rsp_d.q    = valid;
                    rsp_d.data = res_q;
                end
                default: rsp_d.q = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q_r <= '0;
        end else begin
            rsp_q_r <= rsp_d;
        end
    end

    // Routing switches
    always_comb begin
        route = '0;
        unique case (src_mode_e'(mode))
            SRC_SELF: begin
                route.aout_zero = 1'b1;
                route.ext_off   = 1'b1;
                route.loopback  = 1'b1;
            end
            SRC_DACMON: route.loopback = 1'b1;
            default:    route = '0;
        endcase
    end

    assign rsp_valid      = rsp_q_r.valid;
    assign rsp_q          = rsp_q_r.q;
    assign rsp_data       = rsp_q_r.data;
    assign mode_out       = mode;
    assign aout_hold_zero = route.aout_zero;
    assign ext_in_isolate = route.ext_off;
    assign dac_to_adc     = route.loopback;
    assign data_valid     = valid;

    // R7: each request is answered exactly one cycle later
    assert_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R7: the reserved code is always refused
    assert_rsvd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 2'b11)) |=> (rsp_valid && !rsp_q));

    // R4: output held at 0 V only with the external input disconnected
    assert_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
        aout_hold_zero |-> (ext_in_isolate && dac_to_adc && (mode_out == 2'b11)));

    // R9: a rewrite of the held source leaves the flag alone
    assert_same_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && (req_wdata == mode) && valid && !dac_update && !ramp_active)
        |=> data_valid);

endmodule

// File: tb/tb_adc_source_guard.sv
module tb_adc_source_guard;

    localparam int unsigned CLK_HZ  = 10_000;
    localparam int unsigned HOLD_MS = 5;
    localparam int unsigned RES_W   = 16;
    localparam int          HOLD    = (CLK_HZ / 1000) * HOLD_MS;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic [1:0]       req_op;
    logic [1:0]       req_wdata;
    logic             rsp_valid;
    logic             rsp_q;
    logic [RES_W-1:0] rsp_data;
    logic             conv_done;
    logic [RES_W-1:0] conv_data;
    logic             setpoint_zero;
    logic             dac_zero;
    logic             ramp_active;
    logic             dac_update;
    logic [1:0]       mode_out;
    logic             aout_hold_zero;
    logic             ext_in_isolate;
    logic             dac_to_adc;
    logic             data_valid;

    always #5 clk = ~clk;

    adc_source_guard #(
        .CLK_HZ  (CLK_HZ),
        .HOLD_MS (HOLD_MS),
        .RES_W   (RES_W)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_op         (req_op),
        .req_wdata      (req_wdata),
        .rsp_valid      (rsp_valid),
        .rsp_q          (rsp_q),
        .rsp_data       (rsp_data),
        .conv_done      (conv_done),
        .conv_data      (conv_data),
        .setpoint_zero  (setpoint_zero),
        .dac_zero       (dac_zero),
        .ramp_active    (ramp_active),
        .dac_update     (dac_update),
        .mode_out       (mode_out),
        .aout_hold_zero (aout_hold_zero),
        .ext_in_isolate (ext_in_isolate),
        .dac_to_adc     (dac_to_adc),
        .data_valid     (data_valid)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference state, built from the requirements
    logic [1:0]       m_mode;
    logic             m_valid;
    int               m_cnt;
    logic [RES_W-1:0] m_res;
    bit               m_res_known;
    logic             e_rsp_valid;
    logic             e_rsp_q;
    logic [RES_W-1:0] e_rsp_data;
    bit               e_data_chk;

    string tag_mode  = "R2";
    string tag_valid = "R6";
    string tag_route = "R4";
    string tag_rsp   = "R7";

    function automatic logic [2:0] exp_route(input logic [1:0] md);
        case (md)
            2'b11:   return 3'b111;
            2'b10:   return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    function automatic bit self_guard_blocks(input logic [1:0] cur, input logic [1:0] want,
                                             input logic sp0, input logic dz, input logic rmp);
        bit touches = (want != cur) && ((want == 2'b11) || (cur == 2'b11));
        return touches && !(sp0 && dz && !rmp);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_update();
        bit inval;
        bit changed;
        logic [1:0] nmode;
        if (!rst_n) begin
            m_mode = 2'b00; m_valid = 1'b0; m_cnt = HOLD;
            e_rsp_valid = 1'b0; e_rsp_q = 1'b0; e_rsp_data = '0; e_data_chk = 1'b1;
            return;
        end
        nmode = m_mode;
        changed = 1'b0;
        e_rsp_valid = req_valid;
        e_rsp_q = 1'b0;
        e_rsp_data = '0;
        e_data_chk = 1'b1;
        if (req_valid) begin
            case (req_op)
                2'b00: begin
                    e_rsp_q = !self_guard_blocks(m_mode, req_wdata, setpoint_zero, dac_zero, ramp_active);
                    if (e_rsp_q && req_wdata != m_mode) begin
                        nmode = req_wdata;
                        changed = 1'b1;
                    end
                end
                2'b01: begin
                    e_rsp_q = 1'b1;
                    e_rsp_data = RES_W'(m_mode);
                end
                2'b10: begin
                    e_rsp_q = m_valid;
                    e_rsp_data = m_res;
                    e_data_chk = m_res_known;
                end
                default: e_rsp_q = 1'b0;
            endcase
        end
        inval = changed || (dac_update && m_mode[1]) || (ramp_active && m_mode == 2'b10);
        if (inval) m_valid = 1'b0;
        else if (conv_done && m_cnt == 0) m_valid = 1'b1;
        if (inval) m_cnt = HOLD;
        else if (m_cnt != 0) m_cnt = m_cnt - 1;
        if (conv_done) begin
            m_res = conv_data;
            m_res_known = 1'b1;
        end
        m_mode = nmode;
    endtask

    task automatic compare();
        check(tag_mode, "mode_out", int'(mode_out), int'(m_mode));
        check(tag_route, "route{aout,ext,loop}", int'({aout_hold_zero, ext_in_isolate, dac_to_adc}),
              int'(exp_route(m_mode)));
        check(tag_valid, "data_valid", int'(data_valid), int'(m_valid));
        check(tag_rsp, "rsp_valid", int'(rsp_valid), int'(e_rsp_valid));
        if (e_rsp_valid) begin
            check(tag_mode == "R2" ? tag_rsp : tag_mode, "rsp_q", int'(rsp_q), int'(e_rsp_q));
            if (e_data_chk)
                check(tag_valid == "R8" ? "R8" : tag_rsp, "rsp_data", int'(rsp_data), int'(e_rsp_data));
        end
    endtask

    // inputs are set before the call; sampled at the next rising edge
    task automatic step();
        model_update();
        @(negedge clk);
        compare();
        req_valid  = 1'b0;
        conv_done  = 1'b0;
        dac_update = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic req(input logic [1:0] op, input logic [1:0] wd);
        req_valid = 1'b1; req_op = op; req_wdata = wd;
        step();
    endtask

    task automatic conv(input logic [RES_W-1:0] d);
        conv_done = 1'b1; conv_data = d;
        step();
    endtask

    // wait out the hold-off and get a valid result
    task automatic settle(input logic [RES_W-1:0] d);
        idle(HOLD + 1);
        conv(d);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A1C));
        rst_n = 1'b0;
        req_valid = 1'b0; req_op = 2'b00; req_wdata = 2'b00;
        conv_done = 1'b0; conv_data = '0;
        setpoint_zero = 1'b1; dac_zero = 1'b1; ramp_active = 1'b0; dac_update = 1'b0;
        m_res = '0; m_res_known = 1'b0;

        // R1: reset state
        tag_mode = "R1"; tag_valid = "R1"; tag_route = "R1"; tag_rsp = "R1";
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        idle(1);
        tag_route = "R4"; tag_rsp = "R7";

        // R5: strobe one cycle too early, then just in time
        tag_mode = "R2"; tag_valid = "R5";
        req(2'b00, 2'b01);
        idle(HOLD - 1);
        conv(16'h1234);           // sampled at t+HOLD: rejected
        conv(16'h2345);           // sampled at t+HOLD+1: accepted
        tag_rsp = "R7";
        req(2'b10, 2'b00);        // result read, Q=1
        req(2'b01, 2'b00);        // mode read
        req(2'b11, 2'b00);        // reserved code

        // R9: rewrite of held value keeps flag and is accepted
        tag_mode = "R9"; tag_valid = "R9";
        setpoint_zero = 1'b0;
        req(2'b00, 2'b01);
        setpoint_zero = 1'b1;
        idle(2);

        // R6: DAC update and ramp in an analog-input source are ignored
        tag_mode = "R2"; tag_valid = "R6";
        dac_update = 1'b1; step();
        ramp_active = 1'b1; idle(3); ramp_active = 1'b0;
        req(2'b10, 2'b00);
        // monitor: ramp and DAC update invalidate
        req(2'b00, 2'b10);
        settle(16'h0F0F);
        ramp_active = 1'b1; step(); ramp_active = 1'b0;
        settle(16'h0E0E);
        dac_update = 1'b1; step();
        idle(3);

        // R3: self-test guard, each condition failing on entry and on exit
        tag_mode = "R3";
        setpoint_zero = 1'b0; req(2'b00, 2'b11); setpoint_zero = 1'b1;
        dac_zero = 1'b0;      req(2'b00, 2'b11); dac_zero = 1'b1;
        ramp_active = 1'b1;   req(2'b00, 2'b11); ramp_active = 1'b0;
        req(2'b00, 2'b11);
        settle(16'hBEEF);
        dac_update = 1'b1; step();            // R6 in self-test
        ramp_active = 1'b1;   req(2'b00, 2'b00); ramp_active = 1'b0;
        dac_zero = 1'b0;      req(2'b00, 2'b01); dac_zero = 1'b1;
        setpoint_zero = 1'b0; req(2'b00, 2'b10); setpoint_zero = 1'b1;
        req(2'b00, 2'b00);
        settle(16'hCAFE);

        // R8: stored word survives reset, returned with Q=0
        tag_mode = "R2"; tag_valid = "R8";
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
        req(2'b10, 2'b00);
        idle(1);

        // random traffic
        tag_valid = "R6"; tag_mode = "R2";
        for (int i = 0; i < 4000; i++) begin
            req_valid     = ($urandom_range(0, 99) < 30);
            req_op        = 2'($urandom_range(0, 3));
            req_wdata     = 2'($urandom_range(0, 3));
            conv_done     = ($urandom_range(0, 99) < 10);
            conv_data     = RES_W'($urandom);
            setpoint_zero = ($urandom_range(0, 99) < 70);
            dac_zero      = ($urandom_range(0, 99) < 70);
            ramp_active   = ($urandom_range(0, 99) < 4);
            dac_update    = ($urandom_range(0, 99) < 2);
            step();
        end
        ramp_active = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule